// File: doc/BRIEF.md
# Timer Capture / Compare / PWM Unit

This block holds one 16-bit data register whose meaning depends on a 4-bit mode field. As a capture register it grabs the value of an external free-running 16-bit timer when the input pin shows a chosen edge, or only on every 4th or 16th rising edge. As a compare register it watches the same timer and acts when the two are equal: it sets or clears the output pin, raises the interrupt flag alone, or emits a one-cycle special event pulse that a neighbouring timer uses to restart and a converter uses to begin a conversion. As a PWM duty register it shapes a pulse train whose period comes from an external 8-bit timer and its 2-bit prescale phase.

Software reaches the block through a byte-wide port: a control byte (mode plus two fine duty bits) and the two halves of the data register. The interrupt flag is sticky and is cleared by a dedicated request input.

Top module: `ccp_unit`

## Requirements
- R1: The data register is written and read as two bytes: address 1 is bits 7:0, address 2 is bits 15:8; address 3 reads as 0.
- R2: Mode 0000 drives the output pin low from the next clock edge, clears the edge prescaler and clears the latched PWM duty.
- R3: Mode 0100 loads the timer into the data register on each falling edge of the registered pin input, mode 0101 on each rising edge; the load sets the flag and leaves the output pin unchanged.
- R4: Mode 0110 loads on every 4th and mode 0111 on every 16th rising edge counted since the prescaler was last cleared.
- R5: The interrupt flag, once set, stays set until a cycle with the clear request asserted and no new setting event.
- R6: In mode 1000 a match (timer equals data register, on the first cycle of equality) drives the pin high; in mode 1001 it drives the pin low; both set the flag.
- R7: Mode 1010 sets the flag on a match and leaves the pin at its previous level.
- R8: Mode 1011 on a match sets the flag and raises the event output for exactly one cycle, leaving the pin unchanged.
- R9: Modes 11xx make PWM: with the 10-bit count {8-bit timer, 2 prescale bits} at 0 the duty {data bits 7:0, control bits 5:4} is latched and the pin goes high (stays low for duty 0); the pin goes low when the count equals the latched duty.
- R10: The control byte (address 0) stores bits 5:0 (bits 3:0 mode, bits 5:4 fine duty); bits 7:6 read as 0.
- R11: When a capture or match falls in the same cycle as a flag clear request, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 data low, 2 data high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tmr16 | input | 16 | Free-running 16-bit timer value |
| tmr8 | input | 8 | 8-bit PWM timer value |
| tmr8_pre | input | 2 | Prescale phase extending the 8-bit timer |
| pin_in | input | 1 | Capture input pin |
| pin_out | output | 1 | Compare / PWM output pin |
| flag_clr | input | 1 | Software request to clear the flag |
| flag_out | output | 1 | Sticky interrupt flag |
| event_pulse | output | 1 | One-cycle special event (timer restart, conversion start) |

## Verification
The flag can be set by a capture or a compare match in the very cycle that software asks to clear it. The bench raises the clear request at random throughout the capture and compare phases, so it lands on setting cycles many times; a cycle-level model predicts that the flag must end set in those cycles, and such checks carry the R11 tag.

// File: rtl/ccp_pkg.sv
// Shared constants and mode decoding for the capture/compare/PWM unit.
// Assumes a 4-bit mode field whose two upper bits select the function group.
package ccp_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;

    localparam logic [3:0] MODE_OFF      = 4'b0000;
    localparam logic [3:0] MODE_CAP_FALL = 4'b0100;
    localparam logic [3:0] MODE_CAP_RISE = 4'b0101;
    localparam logic [3:0] MODE_CAP_DIVA = 4'b0110;
    localparam logic [3:0] MODE_CAP_DIVB = 4'b0111;
    localparam logic [3:0] MODE_CMP_HI   = 4'b1000;
    localparam logic [3:0] MODE_CMP_LO   = 4'b1001;
    localparam logic [3:0] MODE_CMP_IRQ  = 4'b1010;
    localparam logic [3:0] MODE_CMP_EVT  = 4'b1011;

    function automatic logic is_capture(input logic [3:0] m);
        return m[3:2] == 2'b01;
    endfunction

    function automatic logic is_compare(input logic [3:0] m);
        return m[3:2] == 2'b10;
    endfunction

    function automatic logic is_pwm(input logic [3:0] m);
        return m[3:2] == 2'b11;
    endfunction
endpackage

// File: rtl/ccp_capture.sv
// Edge detector and edge prescaler for capture modes.
// Assumes pin_in is already synchronous to clk; it is registered once more
// here so the edge is seen one cycle after the pin changes.
module ccp_capture #(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode,
    input  logic       pin_in,
    output logic       cap_stb
);
    import ccp_pkg::*;
    localparam int PS_W = $clog2(DIV_B);

    logic            pin_q, pin_p;
    logic [PS_W-1:0] cnt_q;
    logic            rise, fall, last;
    logic [PS_W-1:0] lim;

    // Pin sampling history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            pin_p <= 1'b0;
        end else begin
            pin_q <= pin_in;
            pin_p <= pin_q;
        end
    end

    // Edge decode and capture decision per mode.
    always_comb begin
        rise = pin_q & ~pin_p;
        fall = ~pin_q & pin_p;
        lim  = (mode == MODE_CAP_DIVB) ? PS_W'(DIV_B - 1) : PS_W'(DIV_A - 1);
        last = (cnt_q == lim);
        case (mode)
            MODE_CAP_FALL: cap_stb = fall;
            MODE_CAP_RISE: cap_stb = rise;
            MODE_CAP_DIVA,
            MODE_CAP_DIVB: cap_stb = rise & last;
            default:       cap_stb = 1'b0;
        endcase
    end

    // Rising-edge prescaler, cleared when the block is switched off.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_OFF) begin
            cnt_q <= '0;
        end else if ((mode == MODE_CAP_DIVA || mode == MODE_CAP_DIVB) && rise) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ccp_compare.sv
// Equality detector between the timer and the data register.
// Assumes one action per arrival at the match value: a hit is reported only
// on the first cycle of equality.
module ccp_compare #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    mode,
    input  logic [TW-1:0] tmr,
    input  logic [TW-1:0] ref_val,
    output logic          hit
);
    import ccp_pkg::*;
    logic eq, eq_q;

    // Current equality in compare modes and first-cycle hit.
    always_comb begin
        eq  = is_compare(mode) && (tmr == ref_val);
        hit = eq && !eq_q;
    end

    // Remember last cycle's equality.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end
endmodule

// File: rtl/ccp_pwm.sv
// PWM edge generator: period start at count zero, falling edge at duty.
// Assumes the count {tmr8, tmr_q} steps through every value once per period.
module ccp_pwm #(
    parameter int PW = 8,
    parameter int QW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      mode,
    input  logic [PW-1:0]   tmr8,
    input  logic [QW-1:0]   tmr_q,
    input  logic [PW+QW-1:0] duty_new,
    output logic            go_hi,
    output logic            go_lo
);
    import ccp_pkg::*;
    localparam int DW = PW + QW;

    logic [DW-1:0] cnt, duty_q;
    logic          start;

    // Period start and edge requests.
    always_comb begin
        cnt   = {tmr8, tmr_q};
        start = is_pwm(mode) && (cnt == '0);
        go_hi = start && (duty_new != '0);
        go_lo = (start && duty_new == '0) || (is_pwm(mode) && !start && cnt == duty_q);
    end

    // Duty latched once per period; cleared when the block is off.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_OFF) duty_q <= '0;
        else if (start)                 duty_q <= duty_new;
    end
endmodule

// File: rtl/ccp_unit.sv
// Capture/compare/PWM unit top: register file, flag, event and pin driver.
// Assumes the data register is exactly two bytes and the bus is one byte.
module ccp_unit #(
    parameter int TW    = 16,
    parameter int PW    = 8,
    parameter int DIV_A = 4,
    parameter int DIV_B = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic [TW-1:0] tmr16,
    input  logic [PW-1:0] tmr8,
    input  logic [1:0]    tmr8_pre,
    input  logic          pin_in,
    output logic          pin_out,
    input  logic          flag_clr,
    output logic          flag_out,
    output logic          event_pulse
);
    import ccp_pkg::*;
    localparam int QW = 2;

    logic [5:0]    ctrl_q;
    logic [TW-1:0] val_q;
    logic          pin_q, flag_q, evt_q;
    logic [3:0]    mode;
    logic          cap_stb, hit, go_hi, go_lo;

    assign mode = ctrl_q[3:0];

    ccp_capture #(.DIV_A(DIV_A), .DIV_B(DIV_B)) i_cap (
        .clk(clk), .rst_n(rst_n), .mode(mode), .pin_in(pin_in), .cap_stb(cap_stb)
    );

    ccp_compare #(.TW(TW)) i_cmp (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tmr(tmr16), .ref_val(val_q), .hit(hit)
    );

    ccp_pwm #(.PW(PW), .QW(QW)) i_pwm (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tmr8(tmr8), .tmr_q(tmr8_pre),
        .duty_new({val_q[PW-1:0], ctrl_q[5:4]}), .go_hi(go_hi), .go_lo(go_lo)
    );

    // Control byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ctrl_q <= '0;
        else if (reg_we && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata[5:0];
    end

    // Data register: a capture takes priority over a byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)                             val_q <= '0;
        else if (cap_stb)                       val_q <= tmr16;
        else if (reg_we && reg_addr == ADDR_LO) val_q[7:0]  <= reg_wdata;
        else if (reg_we && reg_addr == ADDR_HI) val_q[15:8] <= reg_wdata;
    end

    // Sticky flag: setting events win over a clear request.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (cap_stb || hit) flag_q <= 1'b1;
        else if (flag_clr)       flag_q <= 1'b0;
    end

    // One-cycle special event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= hit && (mode == MODE_CMP_EVT);
    end

    // Output pin latch shared by compare and PWM.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_OFF) begin
            pin_q <= 1'b0;
        end else if (is_compare(mode)) begin
            if (hit && mode == MODE_CMP_HI)      pin_q <= 1'b1;
            else if (hit && mode == MODE_CMP_LO) pin_q <= 1'b0;
        end else if (is_pwm(mode)) begin
            if (go_hi)      pin_q <= 1'b1;
            else if (go_lo) pin_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {2'b00, ctrl_q};
            ADDR_LO:   reg_rdata = val_q[7:0];
            ADDR_HI:   reg_rdata = val_q[15:8];
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign pin_out     = pin_q;
    assign flag_out    = flag_q;
    assign event_pulse = evt_q;
endmodule

// File: rtl/ccp_unit_chk.sv
// Temporal checks for ccp_unit, attached with bind.
module ccp_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic [3:0] mode,
    input logic       hit,
    input logic       pin_out,
    input logic       flag_clr,
    input logic       flag_out,
    input logic       event_pulse
);
    // R10
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[7:6] == 2'b00));

    // R2
    off_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 4'b0000) |-> !pin_out);

    // R8
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |=> !event_pulse);

    // R8
    evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> flag_out);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_out) && !$past(flag_clr)) |-> flag_out);

    // R6
    set_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) && $past(mode) == 4'b1000) |-> pin_out);
endmodule

bind ccp_unit ccp_unit_chk i_ccp_unit_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .mode(mode), .hit(hit), .pin_out(pin_out), .flag_clr(flag_clr),
    .flag_out(flag_out), .event_pulse(event_pulse)
);

// File: tb/test_ccp_unit.sv
// Self-checking bench: seeded random stimulus plus directed cases, judged
// against a cycle-level reference model built from the requirements.
module test_ccp_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [15:0] tmr16 = 16'h0;
    logic [7:0]  tmr8 = 8'h0;
    logic [1:0]  tmr8_pre = 2'd0;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        flag_clr = 1'b0;
    logic        flag_out;
    logic        event_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    ccp_unit i_ccp_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr16(tmr16),
        .tmr8(tmr8), .tmr8_pre(tmr8_pre), .pin_in(pin_in), .pin_out(pin_out),
        .flag_clr(flag_clr), .flag_out(flag_out), .event_pulse(event_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state.
    logic [5:0]  m_ctrl;
    logic [15:0] m_val;
    logic        m_pq, m_pp, m_eq, m_pin, m_flag, m_evt;
    int          m_cnt;
    logic [9:0]  m_duty;
    logic        last_cap, last_coll;

    // Model advances with the same edge, using pre-edge inputs.
    always @(posedge clk) begin
        logic [3:0] md;
        logic rise, fall, cap, eq, hit, start;
        logic [9:0] c10, dn;
        cyc = cyc + 1;
        if (!rst_n) begin
            m_ctrl = 0; m_val = 0; m_pq = 0; m_pp = 0; m_eq = 0; m_pin = 0;
            m_flag = 0; m_evt = 0; m_cnt = 0; m_duty = 0; last_cap = 0; last_coll = 0;
        end else begin
            md = m_ctrl[3:0];
            rise = m_pq & ~m_pp;
            fall = ~m_pq & m_pp;
            case (md)
                4'b0100: cap = fall;
                4'b0101: cap = rise;
                4'b0110: cap = rise && m_cnt == 3;
                4'b0111: cap = rise && m_cnt == 15;
                default: cap = 1'b0;
            endcase
            eq = (md[3:2] == 2'b10) && (tmr16 == m_val);
            hit = eq && !m_eq;
            c10 = {tmr8, tmr8_pre};
            dn = {m_val[7:0], m_ctrl[5:4]};
            start = (md[3:2] == 2'b11) && c10 == 0;
            if (md == 0) m_pin = 0;
            else if (md[3:2] == 2'b10) begin
                if (hit && md == 4'b1000) m_pin = 1;
                else if (hit && md == 4'b1001) m_pin = 0;
            end else if (md[3:2] == 2'b11) begin
                if (start) m_pin = (dn != 0);
                else if (c10 == m_duty) m_pin = 0;
            end
            if (md == 0) m_duty = 0; else if (start) m_duty = dn;
            if (md == 0) m_cnt = 0;
            else if ((md == 4'b0110 || md == 4'b0111) && rise) m_cnt = cap ? 0 : m_cnt + 1;
            last_coll = (cap || hit) && flag_clr;
            if (cap || hit) m_flag = 1; else if (flag_clr) m_flag = 0;
            m_evt = hit && md == 4'b1011;
            if (cap) m_val = tmr16;
            else if (reg_we && reg_addr == 1) m_val[7:0] = reg_wdata;
            else if (reg_we && reg_addr == 2) m_val[15:8] = reg_wdata;
            if (reg_we && reg_addr == 0) m_ctrl = reg_wdata[5:0];
            last_cap = cap;
            m_pp = m_pq; m_pq = pin_in; m_eq = eq;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {2'b00, m_ctrl};
            2'd1: return m_val[7:0];
            2'd2: return m_val[15:8];
            default: return 8'h00;
        endcase
    endfunction

    // Compare every output against the model, tagging by context.
    task automatic check_all();
        logic [3:0] md;
        string pt, rt;
        md = m_ctrl[3:0];
        if (md == 0) pt = "R2";
        else if (md[3:2] == 2'b11) pt = "R9";
        else if (md == 4'b1000 || md == 4'b1001) pt = "R6";
        else if (md == 4'b1010) pt = "R7";
        else if (md == 4'b1011) pt = "R8";
        else pt = "R3";
        chk(pin_out === m_pin, pt, pin_out, m_pin);
        chk(flag_out === m_flag, last_coll ? "R11" : "R5", flag_out, m_flag);
        chk(event_pulse === m_evt, "R8", event_pulse, m_evt);
        if (reg_addr == 0) rt = "R10";
        else if (last_cap) rt = (md == 4'b0110 || md == 4'b0111) ? "R4" : "R3";
        else rt = "R1";
        chk(reg_rdata === m_read(reg_addr), rt, reg_rdata, m_read(reg_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
        reg_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; flag_clr = 1'b0;
        tick();
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R2, R5, R8)
        chk(pin_out === 1'b0, "R2", pin_out, 0);
        chk(flag_out === 1'b0, "R5", flag_out, 0);
        chk(event_pulse === 1'b0, "R8", event_pulse, 0);

        // R10: upper control bits read as zero
        wr(2'd0, 8'hFF);
        reg_addr = 2'd0;
        chk(reg_rdata === 8'h3F, "R10", reg_rdata, 8'h3F);
        wr(2'd0, 8'h00);
        // R1: byte access
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h12);
        reg_addr = 2'd1; #1;
        chk(reg_rdata === 8'h34, "R1", reg_rdata, 8'h34);
        reg_addr = 2'd2; #1;
        chk(reg_rdata === 8'h12, "R1", reg_rdata, 8'h12);
        reg_addr = 2'd3; #1;
        chk(reg_rdata === 8'h00, "R1", reg_rdata, 0);

        // R3 / R4: capture modes with random pin, timer, clears, reads
        for (int m = 4; m <= 7; m++) begin
            wr(2'd0, 8'(m));
            for (int i = 0; i < 500; i++) begin
                if ($urandom % 3 == 0) pin_in = ~pin_in;
                tmr16 = 16'($urandom);
                flag_clr = ($urandom % 4 == 0);
                reg_addr = 2'($urandom % 4);
                if ($urandom % 40 == 0) begin
                    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'($urandom);
                end
                tick();
            end
            wr(2'd0, 8'h00);
        end

        // R6 / R7 / R8: compare actions, pin high before flag-only mode
        begin
            int seq[4] = '{8, 10, 9, 11};
            for (int k = 0; k < 4; k++) begin
                logic [15:0] v;
                v = 16'($urandom) | 16'h0100;
                wr(2'd1, v[7:0]);
                wr(2'd2, v[15:8]);
                wr(2'd0, 8'(seq[k]));
                tmr16 = v - 16'd20;
                for (int i = 0; i < 300; i++) begin
                    tmr16 = (i % 60 == 0) ? v - 16'd8 : tmr16 + 16'd1;
                    flag_clr = ($urandom % 3 == 0);
                    reg_addr = 2'($urandom % 4);
                    tick();
                end
            end
        end
        flag_clr = 1'b0;
        wr(2'd0, 8'h00);
        // R2: pin low after switching off
        chk(pin_out === 1'b0, "R2", pin_out, 0);

        // R9: PWM with duty 0, full, and random, mid-period duty writes
        for (int k = 0; k < 4; k++) begin
            int d;
            d = (k == 0) ? 0 : (k == 1) ? 1023 : int'($urandom % 1024);
            wr(2'd1, 8'(d >> 2));
            wr(2'd0, 8'h0C | 8'((d & 3) << 4));
            for (int c = 0; c < 2200; c++) begin
                {tmr8, tmr8_pre} = 10'(c);
                reg_addr = 2'($urandom % 4);
                if (k >= 2 && c == 1500) begin
                    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'($urandom);
                end
                tick();
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule